// File: doc/BRIEF.md
# Dual-Clock Bypass Mailbox Pair

This block carries single words straight between two ports that run on unrelated clocks, without going through FIFO storage. It has two independent mailboxes, one word deep each: one carries words from port A to port B, the other from port B to port A. A word written into a mailbox stays in the writer's holding register until the far side reads it. Only then can the writer send the next word.

Port A is the controlling side. It enters bypass mode by chip-selecting with the bypass address, and it leaves by selecting the normal address or by dropping chip-select. The mode is kept in a port-A register. A synchronised copy of it, `b_bypass`, tells port B when bypass transfers are allowed. Each mailbox carries its occupancy across the clock boundary with a toggle request/acknowledge pair.

On each side the data handshake follows valid/ready rules. A write is offered by `en=1, rw=0` and completes only on an edge where `*_wr_ready` is high. A write offered while ready is low is dropped, not stalled, so the writer must hold off until ready returns. A read is offered by `en=1, rw=1` and completes only on an edge where `*_rd_valid` is high. Read data is valid whenever `*_rd_valid` is high and does not change until it is read.

Top module: `byp_bridge`

## Requirements
- R1: After reset, `a_wr_ready` and `b_wr_ready` are 1, and `a_rd_valid`, `b_rd_valid`, `a_bypass` and `b_bypass` are 0.
- R2: A `clk_a` edge with `a_cs_n=0` and `a_addr=3'b001` sets `a_bypass` on that edge. `b_bypass` then rises within SYNC_STAGES+2 `clk_b` edges.
- R3: A `clk_a` edge with `a_cs_n=1`, or with `a_addr=3'b000`, clears `a_bypass`, and `b_bypass` falls within SYNC_STAGES+2 `clk_b` edges. Any other address with `a_cs_n=0` (for example `3'b101`) leaves the mode unchanged.
- R4: Port A writes the A-to-B mailbox on a `clk_a` edge with `a_cs_n=0`, `a_addr=3'b001`, `a_en=1`, `a_rw=0` (rw: 1 = read, 0 = write) and `a_wr_ready=1`. `a_wr_ready` falls on that edge, and `b_rd_valid` later rises with `b_rdata` equal to the written word.
- R5: While a written word is unread, `a_wr_ready` stays 0. Further port-A writes are dropped, and `b_rdata` holds the first word.
- R6: Port B reads on a `clk_b` edge with `b_bypass=1`, `b_en=1`, `b_rw=1` and `b_rd_valid=1`. `b_rd_valid` is 0 after that edge, and `a_wr_ready` returns to 1 within SYNC_STAGES+2 `clk_a` edges.
- R7: The B-to-A mailbox mirrors R4 to R6. Port B writes when `b_bypass=1`, `b_en=1`, `b_rw=0` and `b_wr_ready=1`. Port A reads with the same select as R4 plus `a_en=1`, `a_rw=1`. The unread word in `a_rdata` holds steady.
- R8: Outside bypass mode (`a_cs_n=0` with `a_addr=3'b001` not present on port A, or `b_bypass=0` on port B), writes and reads have no effect. A pending word survives until it is read in bypass mode.
- R9: The two directions work at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_addr | input | 3 | Port A resource address; 001 = bypass, 000 = normal |
| a_rw | input | 1 | Port A direction, 1 = read, 0 = write |
| a_en | input | 1 | Port A transfer enable |
| a_wdata | input | WIDTH | Word written by port A |
| a_wr_ready | output | 1 | A-to-B mailbox free |
| a_rd_valid | output | 1 | B-to-A word waiting for port A |
| a_rdata | output | WIDTH | B-to-A word |
| a_bypass | output | 1 | Bypass mode, port A domain |
| b_rw | input | 1 | Port B direction, 1 = read, 0 = write |
| b_en | input | 1 | Port B transfer enable |
| b_wdata | input | WIDTH | Word written by port B |
| b_wr_ready | output | 1 | B-to-A mailbox free |
| b_rd_valid | output | 1 | A-to-B word waiting for port B |
| b_rdata | output | WIDTH | A-to-B word |
| b_bypass | output | 1 | Bypass mode flag synchronised to `clk_b` |

## Verification
On every edge, the bound assertions check the port-A mode decode and the single-edge behaviour at each side. An accepted write drops ready on the next edge, a completed read drops valid on the next edge, and an unread word stays valid and unchanged unless it is read. Some behaviour only the directed scenarios can show: that a word actually reaches the far port with the right value, the latency bounds of the mode flag and of the returning ready, that a second write into a full mailbox is lost, that transfers outside bypass mode do nothing, and that the two directions run concurrently.

// File: rtl/byp_pkg.sv
package byp_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_NORMAL = 3'b000;
  localparam logic [ADDR_W-1:0] ADDR_BYPASS = 3'b001;

  typedef enum logic [1:0] {
    MODE_KEEP  = 2'd0,
    MODE_ENTER = 2'd1,
    MODE_LEAVE = 2'd2
  } mode_cmd_e;
endpackage

// File: rtl/byp_sync.sv
// Multi-flop synchroniser; STAGES must be 2 or more.
module byp_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/byp_mode_ctl.sv
// Port A mode register: entered and left only by port A selects.
module byp_mode_ctl
  import byp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_now,
  output logic              mode
);
  mode_cmd_e cmd;

  always_comb begin
    cmd = MODE_KEEP;
    if (cs_n || addr == ADDR_NORMAL) cmd = MODE_LEAVE;
    else if (addr == ADDR_BYPASS)    cmd = MODE_ENTER;
  end

  assign sel_now = !cs_n && (addr == ADDR_BYPASS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= 1'b0;
    else begin
      unique case (cmd)
        MODE_ENTER: mode <= 1'b1;
        MODE_LEAVE: mode <= 1'b0;
        default:    mode <= mode;
      endcase
    end
  end
endmodule

// File: rtl/byp_mailbox.sv
// One-word cross-clock mailbox with toggle request/acknowledge.
module byp_mailbox #(
  parameter int unsigned W           = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic         src_push,
  input  logic [W-1:0] src_data,
  output logic         src_ready,
  input  logic         dst_pop,
  output logic         dst_valid,
  output logic [W-1:0] dst_data
);
  logic         req_tgl, ack_tgl;
  logic         req_seen, ack_seen;
  logic [W-1:0] hold_q;

  byp_sync #(.STAGES(SYNC_STAGES), .W(1)) u_ack_sync (
    .clk(src_clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_seen)
  );
  byp_sync #(.STAGES(SYNC_STAGES), .W(1)) u_req_sync (
    .clk(dst_clk), .rst_n(rst_n), .d(req_tgl), .q(req_seen)
  );

  assign src_ready = (req_tgl == ack_seen);

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl <= 1'b0;
      hold_q  <= '0;
    end else if (src_push && src_ready) begin
      req_tgl <= ~req_tgl;
      hold_q  <= src_data;
    end
  end

  assign dst_valid = (req_seen != ack_tgl);
  // Holding register is stable while a word is in flight, so it is read directly.
  assign dst_data  = hold_q;

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n)                    ack_tgl <= 1'b0;
    else if (dst_pop && dst_valid) ack_tgl <= ~ack_tgl;
  end
endmodule

// File: rtl/byp_bridge.sv
module byp_bridge
  import byp_pkg::*;
#(
  parameter int unsigned WIDTH       = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              a_cs_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_rw,
  input  logic              a_en,
  input  logic [WIDTH-1:0]  a_wdata,
  output logic              a_wr_ready,
  output logic              a_rd_valid,
  output logic [WIDTH-1:0]  a_rdata,
  output logic              a_bypass,
  input  logic              b_rw,
  input  logic              b_en,
  input  logic [WIDTH-1:0]  b_wdata,
  output logic              b_wr_ready,
  output logic              b_rd_valid,
  output logic [WIDTH-1:0]  b_rdata,
  output logic              b_bypass
);
  logic a_sel;
  logic a_push, a_pop, b_push, b_pop;

  byp_mode_ctl u_mode (
    .clk(clk_a), .rst_n(rst_n), .cs_n(a_cs_n), .addr(a_addr),
    .sel_now(a_sel), .mode(a_bypass)
  );

  byp_sync #(.STAGES(SYNC_STAGES), .W(1)) u_flag_sync (
    .clk(clk_b), .rst_n(rst_n), .d(a_bypass), .q(b_bypass)
  );

  assign a_push = a_sel && a_en && !a_rw;
  assign a_pop  = a_sel && a_en &&  a_rw;
  assign b_push = b_bypass && b_en && !b_rw;
  assign b_pop  = b_bypass && b_en &&  b_rw;

  byp_mailbox #(.W(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_a2b (
    .src_clk(clk_a), .dst_clk(clk_b), .rst_n(rst_n),
    .src_push(a_push), .src_data(a_wdata), .src_ready(a_wr_ready),
    .dst_pop(b_pop), .dst_valid(b_rd_valid), .dst_data(b_rdata)
  );

  byp_mailbox #(.W(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_b2a (
    .src_clk(clk_b), .dst_clk(clk_a), .rst_n(rst_n),
    .src_push(b_push), .src_data(b_wdata), .src_ready(b_wr_ready),
    .dst_pop(a_pop), .dst_valid(a_rd_valid), .dst_data(a_rdata)
  );
endmodule

// File: rtl/byp_bridge_chk.sv
module byp_bridge_chk #(
  parameter int unsigned WIDTH = 18
) (
  input logic             clk_a,
  input logic             clk_b,
  input logic             rst_n,
  input logic             a_cs_n,
  input logic [2:0]       a_addr,
  input logic             a_rw,
  input logic             a_en,
  input logic             a_wr_ready,
  input logic             a_rd_valid,
  input logic [WIDTH-1:0] a_rdata,
  input logic             a_bypass,
  input logic             b_rw,
  input logic             b_en,
  input logic             b_rd_valid,
  input logic [WIDTH-1:0] b_rdata,
  input logic             b_bypass
);
  logic a_sel_c;
  assign a_sel_c = !a_cs_n && a_addr == 3'b001;

  p_enter_r2: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_sel_c |=> a_bypass);

  p_leave_r3: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_cs_n || a_addr == 3'b000) |=> !a_bypass);

  p_accept_blocks_r5: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_sel_c && a_en && !a_rw && a_wr_ready) |=> !a_wr_ready);

  p_pop_clears_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_bypass && b_en && b_rw && b_rd_valid) |=> !b_rd_valid);

  p_word_stable_r5: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_rd_valid && !(b_bypass && b_en && b_rw)) |=> (b_rd_valid && $stable(b_rdata)));

  p_word_stable_r7: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_rd_valid && !(a_sel_c && a_en && a_rw)) |=> (a_rd_valid && $stable(a_rdata)));

  p_pop_clears_r7: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_sel_c && a_en && a_rw && a_rd_valid) |=> !a_rd_valid);
endmodule

bind byp_bridge byp_bridge_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
  .a_cs_n(a_cs_n), .a_addr(a_addr), .a_rw(a_rw), .a_en(a_en),
  .a_wr_ready(a_wr_ready), .a_rd_valid(a_rd_valid), .a_rdata(a_rdata),
  .a_bypass(a_bypass), .b_rw(b_rw), .b_en(b_en),
  .b_rd_valid(b_rd_valid), .b_rdata(b_rdata), .b_bypass(b_bypass)
);

// File: tb/tb_byp_bridge.sv
module tb_byp_bridge;
  localparam int W = 18;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic a_cs_n = 1'b1, a_rw = 1'b1, a_en = 1'b0, b_rw = 1'b1, b_en = 1'b0;
  logic [2:0] a_addr = 3'b000;
  logic [W-1:0] a_wdata = '0, b_wdata = '0;
  logic a_wr_ready, a_rd_valid, a_bypass, b_wr_ready, b_rd_valid, b_bypass;
  logic [W-1:0] a_rdata, b_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk_a = ~clk_a;
  initial begin #3; forever #4 clk_b = ~clk_b; end

  byp_bridge dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic a_push(input logic [W-1:0] w);
    @(negedge clk_a); a_en = 1; a_rw = 0; a_wdata = w;
    @(negedge clk_a); a_en = 0; a_rw = 1;
  endtask
  task automatic a_pull();
    @(negedge clk_a); a_en = 1; a_rw = 1;
    @(negedge clk_a); a_en = 0;
  endtask
  task automatic b_push(input logic [W-1:0] w);
    @(negedge clk_b); b_en = 1; b_rw = 0; b_wdata = w;
    @(negedge clk_b); b_en = 0; b_rw = 1;
  endtask
  task automatic b_pull();
    @(negedge clk_b); b_en = 1; b_rw = 1;
    @(negedge clk_b); b_en = 0;
  endtask
  task automatic wait_b_valid();
    for (int i = 0; i < 8 && !b_rd_valid; i++) @(negedge clk_b);
  endtask
  task automatic wait_a_valid();
    for (int i = 0; i < 8 && !a_rd_valid; i++) @(negedge clk_a);
  endtask
  task automatic enter_mode();
    @(negedge clk_a); a_cs_n = 0; a_addr = 3'b001;
    @(negedge clk_a);
    for (int i = 0; i < 4 && !b_bypass; i++) @(negedge clk_b);
  endtask

  task automatic t_reset();
    chk(a_wr_ready && b_wr_ready, "R1 wr_ready", {a_wr_ready, b_wr_ready}, 2'b11);
    chk(!a_rd_valid && !b_rd_valid, "R1 rd_valid", {a_rd_valid, b_rd_valid}, 0);
    chk(!a_bypass && !b_bypass, "R1 bypass", {a_bypass, b_bypass}, 0);
  endtask

  task automatic t_enter();
    @(negedge clk_a); a_cs_n = 0; a_addr = 3'b001;
    @(negedge clk_a);
    chk(a_bypass, "R2 a_bypass set", a_bypass, 1);
    for (int i = 0; i < 4 && !b_bypass; i++) @(negedge clk_b);
    chk(b_bypass, "R2 b_bypass within bound", b_bypass, 1);
  endtask

  task automatic t_ab_word();
    a_push(18'h2A5C3);
    chk(!a_wr_ready, "R4 ready drops", a_wr_ready, 0);
    wait_b_valid();
    chk(b_rd_valid && b_rdata == 18'h2A5C3, "R4 word at B", b_rdata, 18'h2A5C3);
    b_pull();
    chk(!b_rd_valid, "R6 valid clears", b_rd_valid, 0);
    for (int i = 0; i < 4 && !a_wr_ready; i++) @(negedge clk_a);
    chk(a_wr_ready, "R6 ready returns", a_wr_ready, 1);
  endtask

  task automatic t_one_deep();
    a_push(18'h11111);
    wait_b_valid();
    a_push(18'h0BEEF);
    chk(!a_wr_ready, "R5 ready held low", a_wr_ready, 0);
    repeat (4) @(negedge clk_b);
    chk(b_rdata == 18'h11111, "R5 first word kept", b_rdata, 18'h11111);
    b_pull();
    repeat (10) @(negedge clk_b);
    chk(!b_rd_valid, "R5 second write dropped", b_rd_valid, 0);
  endtask

  task automatic t_ba_word();
    b_push(18'h3C0F1);
    chk(!b_wr_ready, "R7 b ready drops", b_wr_ready, 0);
    wait_a_valid();
    chk(a_rd_valid && a_rdata == 18'h3C0F1, "R7 word at A", a_rdata, 18'h3C0F1);
    a_pull();
    chk(!a_rd_valid, "R7 a valid clears", a_rd_valid, 0);
    for (int i = 0; i < 4 && !b_wr_ready; i++) @(negedge clk_b);
    chk(b_wr_ready, "R7 b ready returns", b_wr_ready, 1);
  endtask

  task automatic t_both();
    fork
      a_push(18'h12345);
      b_push(18'h2FEDC);
    join
    wait_b_valid();
    wait_a_valid();
    chk(b_rd_valid && b_rdata == 18'h12345, "R9 A to B", b_rdata, 18'h12345);
    chk(a_rd_valid && a_rdata == 18'h2FEDC, "R9 B to A", a_rdata, 18'h2FEDC);
    fork
      a_pull();
      b_pull();
    join
    chk(!a_rd_valid && !b_rd_valid, "R9 both drained", {a_rd_valid, b_rd_valid}, 0);
  endtask

  task automatic t_addr_hold();
    @(negedge clk_a); a_addr = 3'b101;
    @(negedge clk_a);
    chk(a_bypass, "R3 other address holds", a_bypass, 1);
    repeat (4) @(negedge clk_b);
    chk(b_bypass, "R3 b flag holds", b_bypass, 1);
    @(negedge clk_a); a_addr = 3'b000;
    @(negedge clk_a);
    chk(!a_bypass, "R3 normal address clears", a_bypass, 0);
    for (int i = 0; i < 4 && b_bypass; i++) @(negedge clk_b);
    chk(!b_bypass, "R3 b flag falls", b_bypass, 1'b0);
    enter_mode();
    @(negedge clk_a); a_cs_n = 1;
    @(negedge clk_a);
    chk(!a_bypass, "R3 deselect clears", a_bypass, 0);
    for (int i = 0; i < 4 && b_bypass; i++) @(negedge clk_b);
  endtask

  task automatic t_idle_ignored();
    a_push(18'h0AAAA);
    repeat (8) @(negedge clk_b);
    chk(a_wr_ready && !b_rd_valid, "R8 A write ignored", {a_wr_ready, b_rd_valid}, 2'b10);
    b_push(18'h05555);
    repeat (8) @(negedge clk_a);
    chk(b_wr_ready && !a_rd_valid, "R8 B write ignored", {b_wr_ready, a_rd_valid}, 2'b10);
    enter_mode();
    a_push(18'h07777);
    wait_b_valid();
    @(negedge clk_a); a_cs_n = 1;
    for (int i = 0; i < 4 && b_bypass; i++) @(negedge clk_b);
    b_pull();
    chk(b_rd_valid, "R8 B read ignored", b_rd_valid, 1);
    enter_mode();
    chk(b_rdata == 18'h07777, "R8 word survives", b_rdata, 18'h07777);
    b_pull();
    chk(!b_rd_valid, "R8 read after re-entry", b_rd_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_a);
    t_reset();
    @(negedge clk_a); rst_n = 1;
    repeat (2) @(negedge clk_a);
    t_enter();
    t_ab_word();
    t_one_deep();
    t_ba_word();
    t_both();
    t_addr_hold();
    t_idle_ignored();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk_a);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule